// File: doc/BRIEF.md
# Down-counting interval timer with register access

This block is a single timer channel reached through a plain 32-bit register bus. The bus has a write strobe, a read strobe, a byte offset, write data and read data. Software writes a 64-bit reload value as two 32-bit words and sets an enable bit. On the first timer tick after enabling, the counter loads the reload value. From then on it moves down by one on every tick. Everything runs on one clock, and a `tick` input marks the cycles on which the counter may step.

When the count is zero, the next tick is an expiry. In periodic mode an expiry reloads the counter, so a reload value of N gives one expiry every N+1 ticks. In single-count mode an expiry parks the counter at zero until software clears the enable bit and sets it again. Each expiry sets a sticky status bit, which software clears by writing a one to it. The interrupt output follows that status bit only while the unmask bit in the control register is set.

A parameter places the control register at one of two offsets. The counter is driven by a three-state machine:
- IDLE: disabled, or waiting for the first tick after enabling.
- RUN: counting.
- HOLD: a single-count run has finished.

The transitions are:
- IDLE→RUN: enabled and a tick arrives; the reload value is loaded.
- RUN→RUN: a tick arrives; the count decrements, or it reloads on a periodic expiry.
- RUN→HOLD: a single-count expiry.
- Any state→IDLE: enable is cleared.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset, every readable register returns zero: reload words, count words, control and status. The interrupt output is low.
- R2: The low reload word is written and read at offset 0x00 and the high word at 0x04. The low count word is read at 0x08 and the high count word at 0x0C.
- R3: The control register is at 0x10 when parameter CTRL_ALT is 0 and at 0x1C when it is 1. It reads back bits [2:0] as written, and all other bits read as zero. The offset not selected reads zero and ignores writes.
- R4: Control bit 0 (enable) is a 0-to-1 change when it is written with 1 while previously 0. The first tick after such a change loads all 64 bits of the reload value into the count. Until that tick the count keeps its old value.
- R5: While the timer is running, each tick lowers the 64-bit count by exactly one, with the borrow carried across the word boundary. A cycle without a tick leaves the count unchanged. With a reload value of all ones, the bitwise inverse of the count equals the number of ticks since the load.
- R6: When control bit 1 is 0 (periodic), a tick seen while the count is zero sets status bit 0 and reloads the counter. With reload value N and the load on tick 1, expiries fall on ticks N+2, 2N+3, and so on.
- R7: When control bit 1 is 1 (single count), the expiry on tick N+2 sets status bit 0. The count then stays at zero and no further expiry occurs until enable is cleared and set again. The first tick after re-enabling loads the reload value again.
- R8: Status is read at offset 0x18 in bit 0. Writing a 1 to bit 0 clears it, and writing a 0 leaves it unchanged. If an expiry and a clear happen in the same cycle, the status stays set.
- R9: The interrupt output is high exactly when status bit 0 and control bit 2 (unmask) are both 1. With bit 2 at 0, an expiry sets status but the output stays low.
- R10: Writing 0 to control bit 0 stops the counter. Later ticks leave the count at its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; the counter steps on cycles where this is high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is zero while low |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational from addr |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume the following about the inputs:
- `tick` may be high on any cycle, including the cycle of a control write.
- Reload words may change while the counter is running, and the change only takes effect at the next load.
- The register offsets are 4-byte aligned.

The sweeps write only aligned offsets. They space ticks either back to back or with idle cycles between them. They change mode and unmask only while the counter is stopped or not ticking, except in one case: a status clear is deliberately issued on the same cycle as an expiry, to exercise the rule that the set wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    // control fields, bit 0 = run, bit 1 = single, bit 2 = unmask
    typedef struct packed {
        logic unmask;
        logic single;
        logic run;
    } tmr_ctrl_t;

    localparam int CTRL_BITS = 3;

    localparam logic [4:0] OFS_RLD_LO = 5'h00;
    localparam logic [4:0] OFS_RLD_HI = 5'h04;
    localparam logic [4:0] OFS_CNT_LO = 5'h08;
    localparam logic [4:0] OFS_CNT_HI = 5'h0C;
    localparam logic [4:0] OFS_CTL_A  = 5'h10;
    localparam logic [4:0] OFS_STAT   = 5'h18;
    localparam logic [4:0] OFS_CTL_B  = 5'h1C;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter bit CTRL_ALT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [2*DATA_W-1:0]   count,
    input  logic                  expire,
    output logic [2*DATA_W-1:0]   reload,
    output tmr_ctrl_t             ctrl,
    output logic                  status
);
    localparam int CNT_W = 2 * DATA_W;

    logic [ADDR_W-1:0] ctrl_ofs;

    if (CTRL_ALT) begin : g_ctrl_b
        assign ctrl_ofs = ADDR_W'(OFS_CTL_B);
    end else begin : g_ctrl_a
        assign ctrl_ofs = ADDR_W'(OFS_CTL_A);
    end

    logic hit_lo, hit_hi, hit_ctl, hit_st;
    assign hit_lo  = (addr == ADDR_W'(OFS_RLD_LO));
    assign hit_hi  = (addr == ADDR_W'(OFS_RLD_HI));
    assign hit_ctl = (addr == ctrl_ofs);
    assign hit_st  = (addr == ADDR_W'(OFS_STAT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
            ctrl   <= '0;
            status <= 1'b0;
        end else begin
            if (wr_en && hit_lo) reload[DATA_W-1:0]     <= wdata;
            if (wr_en && hit_hi) reload[CNT_W-1:DATA_W] <= wdata;
            if (wr_en && hit_ctl) ctrl <= tmr_ctrl_t'(wdata[CTRL_BITS-1:0]);
            if (expire)
                status <= 1'b1;
            else if (wr_en && hit_st && wdata[0])
                status <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_lo)
                rdata = reload[DATA_W-1:0];
            else if (hit_hi)
                rdata = reload[CNT_W-1:DATA_W];
            else if (addr == ADDR_W'(OFS_CNT_LO))
                rdata = count[DATA_W-1:0];
            else if (addr == ADDR_W'(OFS_CNT_HI))
                rdata = count[CNT_W-1:DATA_W];
            else if (hit_ctl)
                rdata = DATA_W'(ctrl);
            else if (hit_st)
                rdata = DATA_W'(status);
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             single,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output tmr_state_e       state
);
    tmr_state_e state_d;
    logic       do_load;
    logic       do_dec;
    logic       at_zero;

    assign at_zero = (count == '0);

    // state register and count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
        end else begin
            state <= state_d;
            if (do_load)
                count <= reload;
            else if (do_dec)
                count <= count - CNT_W'(1);
        end
    end

    // next state and per-cycle actions
    always_comb begin
        state_d = state;
        do_load = 1'b0;
        do_dec  = 1'b0;
        expire  = 1'b0;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tick) begin
                        do_load = 1'b1;
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (at_zero) begin
                            expire = 1'b1;
                            if (single)
                                state_d = ST_HOLD;
                            else
                                do_load = 1'b1;
                        end else begin
                            do_dec = 1'b1;
                        end
                    end
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter bit CTRL_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] rld_val;
    tmr_ctrl_t        ctl;
    logic             stat;
    logic             expire;
    tmr_state_e       core_state;

    tmr_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CTRL_ALT (CTRL_ALT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .count  (cnt_val),
        .expire (expire),
        .reload (rld_val),
        .ctrl   (ctl),
        .status (stat)
    );

    tmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (ctl.run),
        .single (ctl.single),
        .reload (rld_val),
        .count  (cnt_val),
        .expire (expire),
        .state  (core_state)
    );

    assign irq = stat & ctl.unmask;

endmodule

// File: rtl/tmr_down_timer_chk.sv
module tmr_down_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic             unmask,
    input logic             irq,
    input logic             expire,
    input logic             status,
    input logic [CNT_W-1:0] count,
    input tmr_state_e       state
);

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && state == ST_RUN && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R5

    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R5

    AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status); // R6

    AST_STATUS_FROM_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(expire)); // R6

    AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (count == '0)); // R7

    AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (unmask && status)); // R9

    AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count)); // R10

endmodule

bind tmr_down_timer tmr_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (ctl.run),
    .unmask (ctl.unmask),
    .irq    (irq),
    .expire (expire),
    .status (stat),
    .count  (cnt_val),
    .state  (core_state)
);

// File: tb/tb_tmr_down_timer.sv
`timescale 1ns/1ps
module tb_tmr_down_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_a;
    logic        irq, irq_a;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_down_timer #(.CTRL_ALT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    tmr_down_timer #(.CTRL_ALT(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_a), .irq(irq_a));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic t = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic [31:0] da);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata; da = rdata_a;
        rd_en = 1'b0;
    endtask

    task automatic rd_cnt(output logic [63:0] c);
        logic [31:0] lo, hi, x;
        rd(5'h08, lo, x);
        rd(5'h0C, hi, x);
        c = {hi, lo};
    endtask

    task automatic tk(input int n, input int gap = 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, da;
        logic [63:0] c;
        bit bad;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), d, da);
            chk("R1 dut reg", {32'h0, d}, 64'h0);
            chk("R1 alt reg", {32'h0, da}, 64'h0);
        end
        chk("R1 irq", {63'h0, irq | irq_a}, 64'h0);

        // R2 reload words
        wr(5'h00, 32'h1234_5678);
        wr(5'h04, 32'h9ABC_DEF0);
        rd(5'h00, d, da); chk("R2 reload lo", {32'h0, d}, 64'h1234_5678);
        rd(5'h04, d, da); chk("R2 reload hi", {32'h0, d}, 64'h9ABC_DEF0);

        // R3 control offset per variant
        wr(5'h10, 32'hFFFF_FFF6);
        rd(5'h10, d, da);
        chk("R3 dut ctrl readback", {32'h0, d}, 64'h6);
        chk("R3 alt ignores 0x10", {32'h0, da}, 64'h0);
        wr(5'h1C, 32'h0000_0006);
        rd(5'h1C, d, da);
        chk("R3 alt ctrl readback", {32'h0, da}, 64'h6);
        chk("R3 dut 0x1C unmapped", {32'h0, d}, 64'h0);
        wr(5'h10, 32'h0);
        wr(5'h1C, 32'h0);

        // R4 load on first tick after enable
        wr(5'h00, 32'h5);
        wr(5'h04, 32'h1);
        wr(5'h10, 32'h1);
        rd_cnt(c); chk("R4 no load before tick", c, 64'h0);
        tk(1);
        rd_cnt(c); chk("R4 full 64-bit load", c, 64'h1_0000_0005);
        tk(5);
        rd_cnt(c); chk("R5 decrement", c, 64'h1_0000_0000);
        tk(1);
        rd_cnt(c); chk("R5 borrow across words", c, 64'h0_FFFF_FFFF);
        repeat (3) @(negedge clk);
        rd_cnt(c); chk("R5 still without tick", c, 64'h0_FFFF_FFFF);

        // R10 stop holds value
        wr(5'h10, 32'h0);
        tk(3);
        rd_cnt(c); chk("R10 stopped count", c, 64'h0_FFFF_FFFF);

        // R5 all ones reload: inverse equals elapsed ticks
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h10, 32'h1);
        tk(1);
        tk(6, 1);
        rd_cnt(c); chk("R5 inverse elapsed", ~c, 64'd6);
        wr(5'h10, 32'h0);

        // R6 periodic sweep, R9 masked irq
        for (int gap = 0; gap <= 2; gap += 2) begin
            for (int n = 0; n <= 5; n++) begin
                bad = 1'b0;
                wr(5'h10, 32'h0);
                wr(5'h18, 32'h1);
                wr(5'h00, 32'(n));
                wr(5'h04, 32'h0);
                wr(5'h10, 32'h1);
                for (int t = 1; t <= 2 * n + 3; t++) begin
                    tk(1, gap);
                    rd(5'h18, d, da);
                    if (d[0] !== ((t == n + 2) || (t == 2 * n + 3))) bad = 1'b1;
                    if (irq !== 1'b0) bad = 1'b1;
                    if (d[0]) wr(5'h18, 32'h1);
                end
                chk($sformatf("R6 periodic n=%0d gap=%0d", n, gap), {63'h0, bad}, 64'h0);
            end
        end

        // R7 single-count sweep
        for (int n = 0; n <= 4; n++) begin
            bad = 1'b0;
            wr(5'h10, 32'h0);
            wr(5'h18, 32'h1);
            wr(5'h00, 32'(n));
            wr(5'h04, 32'h0);
            wr(5'h10, 32'h3);
            for (int t = 1; t <= n + 5; t++) begin
                tk(1);
                rd(5'h18, d, da);
                if (d[0] !== (t == n + 2)) bad = 1'b1;
                if (d[0]) wr(5'h18, 32'h1);
            end
            chk($sformatf("R7 single status n=%0d", n), {63'h0, bad}, 64'h0);
            rd_cnt(c); chk($sformatf("R7 held zero n=%0d", n), c, 64'h0);
            wr(5'h10, 32'h0);
            wr(5'h10, 32'h3);
            tk(1);
            rd_cnt(c); chk($sformatf("R7 reload after re-enable n=%0d", n), c, 64'(n));
        end

        // R9 unmask gating
        wr(5'h10, 32'h0);
        wr(5'h18, 32'h1);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h1);
        tk(2);
        rd(5'h18, d, da);
        chk("R9 status set while masked", {63'h0, d[0]}, 64'h1);
        chk("R9 irq low while masked", {63'h0, irq}, 64'h0);
        wr(5'h10, 32'h5);
        #1 chk("R9 irq high when unmasked", {63'h0, irq}, 64'h1);

        // R8 clear semantics
        wr(5'h18, 32'h0);
        rd(5'h18, d, da);
        chk("R8 write 0 keeps status", {63'h0, d[0]}, 64'h1);
        wr(5'h18, 32'h1, 1'b1);
        rd(5'h18, d, da);
        chk("R8 set wins over clear", {63'h0, d[0]}, 64'h1);
        wr(5'h18, 32'h1);
        rd(5'h18, d, da);
        chk("R8 write 1 clears", {63'h0, d[0]}, 64'h0);
        chk("R9 irq low after clear", {63'h0, irq}, 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule